// File: doc/BRIEF.md
# Strobed Serial-to-Parallel Output Latch

This block turns a slow serial stream into a parallel output word. An external controller drives four pins: a serial clock, a serial data line, an active-low strobe and an active-low clear. Every rising edge of the serial clock moves the data line into a shift register. A storage stage sits between the shift register and the parallel outputs and behaves as a level-sensitive latch. While the strobe is low the latch is open, so the outputs track the shift register. While the strobe is high the latch is closed and the outputs keep their value.

The clear pin forces every latch bit, and with them every parallel output, to logic high. It leaves the shift register alone. The last stage of the shift register also drives a cascade pin, so several blocks can be chained. Normal use is to clock in exactly WIDTH bits and then pulse the strobe low. After that load, the first bit sent sits at the most significant output.

All logic runs on one system clock with a synchronous active-high reset. The four pins are asynchronous to that clock and each passes through its own synchronizer. WIDTH is meant to stay between 8 and 24.

Top module: `sipo_strobe_latch`

## Requirements
- R1: On each rising edge of the serial clock pin, the shift register takes the data pin into bit 0 and moves every other bit i up from bit i-1. The new contents reach the outputs at the third system clock edge after the pin rises.
- R2: While the synchronized strobe is low and clear is high, par_q_o equals the shift register contents.
- R3: While the strobe is high and clear is high, par_q_o does not change, even when serial clock edges keep shifting data.
- R4: With the strobe held low during clocking, every single-bit shift changes par_q_o to the new shift register value. No separate strobe pulse is needed.
- R5: Clear low forces every bit of par_q_o to 1 and presets the latch to all ones. The shift register keeps its contents, which the next strobe pulse after clear is released makes visible.
- R6: cascade_o equals the most significant shift register bit. It changes only on serial clock rising edges and is independent of the strobe and clear.
- R7: After exactly WIDTH serial clock edges, the first bit sent appears on par_q_o[WIDTH-1] and the last on par_q_o[0].
- R8: After reset, the shift register is all zeros, par_q_o is all ones and cascade_o is 0.
- R9: When clear and strobe are both low, clear takes priority and par_q_o is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk_i | input | 1 | Asynchronous serial clock; data shifts on its rising edge |
| ser_data_i | input | 1 | Asynchronous serial data |
| strobe_n_i | input | 1 | Asynchronous latch strobe; low opens the latch |
| clear_n_i | input | 1 | Asynchronous clear; low presets outputs to ones |
| par_q_o | output | WIDTH | Parallel output word |
| cascade_o | output | 1 | Last shift register stage, for chaining |

## Verification
A serial clock rise reaches the shift register, par_q_o and cascade_o at the third system clock edge after the pin changes: two synchronizer flops, then the edge-detect register. A change on the strobe or clear pin reaches par_q_o at the second edge. The bench drives pins on falling edges and holds each level for at least four system cycles. It pushes expected values into its queue only after that settling window has passed, so every comparison lands on a stable output. The data pin is set three cycles before the serial clock rises and stays put until the clock falls, so sampling never straddles a data change.

// File: rtl/sipo_pkg.sv
package sipo_pkg;

    localparam int WIDTH_MIN = 8;
    localparam int WIDTH_MAX = 24;

    // The four asynchronous control pins, carried together.
    typedef struct packed {
        logic sclk;
        logic sdat;
        logic strb_n;
        logic clr_n;
    } pin_t;

    localparam pin_t PIN_IDLE = '{sclk: 1'b0, sdat: 1'b0, strb_n: 1'b1, clr_n: 1'b1};

    // State of the storage stage.
    typedef enum logic [1:0] {
        LM_HOLD  = 2'd0,
        LM_OPEN  = 2'd1,
        LM_CLEAR = 2'd2
    } latch_mode_e;

    // Clear has priority over the strobe.
    function automatic latch_mode_e latch_mode(input logic strb_n, input logic clr_n);
        if (!clr_n)       return LM_CLEAR;
        else if (!strb_n) return LM_OPEN;
        else              return LM_HOLD;
    endfunction

endpackage

// File: rtl/sipo_sync.sv
module sipo_sync #(
    parameter int          N       = 4,
    parameter int          STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);
    logic [N-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[s] <= RST_VAL;
            else     stg[s] <= stg[s-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sipo_shift.sv
module sipo_shift #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk_i,
    input  logic             sdat_i,
    output logic [WIDTH-1:0] shift_q_o,
    output logic             rise_o
);
    logic sclk_d;

    always_ff @(posedge clk) begin
        if (rst) sclk_d <= 1'b0;
        else     sclk_d <= sclk_i;
    end

    assign rise_o = sclk_i & ~sclk_d;

    always_ff @(posedge clk) begin
        if (rst)         shift_q_o <= '0;
        else if (rise_o) shift_q_o <= {shift_q_o[WIDTH-2:0], sdat_i};
    end
endmodule

// File: rtl/sipo_store.sv
module sipo_store
    import sipo_pkg::*;
#(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] shift_q_i,
    input  logic             strb_n_i,
    input  logic             clr_n_i,
    output logic [WIDTH-1:0] par_q_o
);
    logic [WIDTH-1:0] lat_q;
    latch_mode_e      mode;

    assign mode = latch_mode(strb_n_i, clr_n_i);

    // Output side of the latch: open lets the shift word straight through.
    always_comb begin
        unique case (mode)
            LM_CLEAR: par_q_o = '1;
            LM_OPEN:  par_q_o = shift_q_i;
            default:  par_q_o = lat_q;
        endcase
    end

    // Stored side: keeps whatever was last passed through.
    always_ff @(posedge clk) begin
        if (rst) lat_q <= '1;
        else begin
            unique case (mode)
                LM_CLEAR: lat_q <= '1;
                LM_OPEN:  lat_q <= shift_q_i;
                default:  lat_q <= lat_q;
            endcase
        end
    end
endmodule

// File: rtl/sipo_strobe_latch.sv
module sipo_strobe_latch
    import sipo_pkg::*;
#(
    parameter int WIDTH       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_clk_i,
    input  logic             ser_data_i,
    input  logic             strobe_n_i,
    input  logic             clear_n_i,
    output logic [WIDTH-1:0] par_q_o,
    output logic             cascade_o
);
    localparam int PIN_W = $bits(pin_t);

    pin_t             pin_raw;
    pin_t             pin_syn;
    logic [WIDTH-1:0] shift_q;
    logic             rise;

    assign pin_raw = '{sclk: ser_clk_i, sdat: ser_data_i,
                       strb_n: strobe_n_i, clr_n: clear_n_i};

    sipo_sync #(
        .N       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pin_raw),
        .q_o (pin_syn)
    );

    sipo_shift #(.WIDTH(WIDTH)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .sclk_i    (pin_syn.sclk),
        .sdat_i    (pin_syn.sdat),
        .shift_q_o (shift_q),
        .rise_o    (rise)
    );

    sipo_store #(.WIDTH(WIDTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .shift_q_i (shift_q),
        .strb_n_i  (pin_syn.strb_n),
        .clr_n_i   (pin_syn.clr_n),
        .par_q_o   (par_q_o)
    );

    assign cascade_o = shift_q[WIDTH-1];
endmodule

// File: rtl/sipo_strobe_latch_chk.sv
module sipo_strobe_latch_chk #(
    parameter int WIDTH = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             rise,
    input logic             sdat,
    input logic             strb_n,
    input logic             clr_n,
    input logic [WIDTH-1:0] shift_q,
    input logic [WIDTH-1:0] par_q_o,
    input logic             cascade_o
);
    // R1: a detected edge shifts exactly one position
    a_r1_shift_step: assert property (@(posedge clk) disable iff (rst)
        $past(rise) |-> shift_q == {$past(shift_q[WIDTH-2:0]), $past(sdat)});

    // R2: an open latch shows the shift word
    a_r2_open_follows: assert property (@(posedge clk) disable iff (rst)
        (!strb_n && clr_n) |-> par_q_o == shift_q);

    // R3: a closed latch keeps the outputs steady
    a_r3_hold_steady: assert property (@(posedge clk) disable iff (rst)
        (strb_n && clr_n && $past(strb_n) && $past(clr_n)) |-> $stable(par_q_o));

    // R5: clear forces all ones on the outputs
    a_r5_clear_ones: assert property (@(posedge clk) disable iff (rst)
        !clr_n |-> &par_q_o);

    // R5: clear leaves the shift register alone
    a_r5_clear_keeps_shift: assert property (@(posedge clk) disable iff (rst)
        (!clr_n && !$past(rise)) |-> $stable(shift_q));

    // R6: cascade moves only on a shift
    a_r6_cascade_on_edge: assert property (@(posedge clk) disable iff (rst)
        !$past(rise) |-> $stable(cascade_o));

    // R8: state right after reset
    a_r8_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&par_q_o && !cascade_o && shift_q == '0));

    // R9: clear wins over an open strobe
    a_r9_clear_priority: assert property (@(posedge clk) disable iff (rst)
        (!clr_n && !strb_n) |-> &par_q_o);
endmodule

bind sipo_strobe_latch sipo_strobe_latch_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rise      (rise),
    .sdat      (pin_syn.sdat),
    .strb_n    (pin_syn.strb_n),
    .clr_n     (pin_syn.clr_n),
    .shift_q   (shift_q),
    .par_q_o   (par_q_o),
    .cascade_o (cascade_o)
);

// File: tb/sipo_strobe_latch_bench.sv
module sipo_strobe_latch_bench;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ser_clk = 1'b0;
    logic         ser_data = 1'b0;
    logic         strobe_n = 1'b1;
    logic         clear_n = 1'b1;
    logic [W-1:0] par_q;
    logic         cascade;

    always #4 clk = ~clk;

    sipo_strobe_latch #(.WIDTH(W)) u_sipo_strobe_latch (
        .clk        (clk),
        .rst        (rst),
        .ser_clk_i  (ser_clk),
        .ser_data_i (ser_data),
        .strobe_n_i (strobe_n),
        .clear_n_i  (clear_n),
        .par_q_o    (par_q),
        .cascade_o  (cascade)
    );

    typedef struct {
        logic [W-1:0] par;
        logic         casc;
        string        tag;
    } exp_t;

    exp_t q[$];
    int   checks   = 0;
    int   failures = 0;
    logic [W-1:0] m_sh  = '0;
    logic [W-1:0] m_lat = '1;
    bit   done = 0;

    function automatic logic [W-1:0] exp_par();
        if (!clear_n)       return '1;
        else if (!strobe_n) return m_sh;
        else                return m_lat;
    endfunction

    function automatic void upd_lat();
        if (!clear_n)       m_lat = '1;
        else if (!strobe_n) m_lat = m_sh;
    endfunction

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic push(input string tag);
        exp_t e;
        e.par  = exp_par();
        e.casc = m_sh[W-1];
        e.tag  = tag;
        q.push_back(e);
        wait_neg(2);
    endtask

    task automatic send_bit(input logic b, input string tag);
        ser_data = b;
        wait_neg(3);
        ser_clk = 1'b1;
        wait_neg(4);
        ser_clk = 1'b0;
        wait_neg(4);
        m_sh = {m_sh[W-2:0], b};
        upd_lat();
        push(tag);
    endtask

    task automatic set_pins(input logic s_n, input logic c_n, input string tag);
        strobe_n = s_n;
        clear_n  = c_n;
        wait_neg(4);
        upd_lat();
        push(tag);
    endtask

    // Monitor: pops each expected item and compares it at a falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (par_q !== e.par || cascade !== e.casc) begin
                    failures++;
                    $display("FAIL %s: par=%h casc=%b expected par=%h casc=%b",
                             e.tag, par_q, cascade, e.par, e.casc);
                end
            end
        end
    end

    // Watchdog
    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] pat_a = 12'hA5C;
        logic [W-1:0] pat_b = 12'h3C1;
        wait_neg(5);
        rst = 1'b0;
        wait_neg(2);
        push("R8 reset state");

        // Load a full word with the latch closed: outputs hold, cascade tracks
        for (int i = W - 1; i >= 0; i--) send_bit(pat_a[i], "R3/R6 shift while held");
        set_pins(1'b0, 1'b1, "R2/R7 strobe open shows loaded word");
        set_pins(1'b1, 1'b1, "R3 strobe closed keeps word");

        // More shifting with latch closed
        for (int i = 0; i < 3; i++) send_bit(i[0], "R1/R3 extra shifts held");

        // Transparent shifting: each bit reaches the outputs
        set_pins(1'b0, 1'b1, "R2 open latch");
        for (int i = W - 1; i >= W - 5; i--) send_bit(pat_b[i], "R4 transparent shift");

        // Clear while strobe open: clear wins
        set_pins(1'b0, 1'b0, "R9 clear beats strobe");
        set_pins(1'b1, 1'b0, "R5 clear alone");
        send_bit(1'b1, "R5/R6 shift during clear");
        set_pins(1'b1, 1'b1, "R5 latch preset after clear release");
        set_pins(1'b0, 1'b1, "R5 shift register kept through clear");
        set_pins(1'b1, 1'b1, "R3 close again");

        // Second full load, first bit must land at the top
        for (int i = W - 1; i >= 0; i--) send_bit(pat_b[i], "R1/R6 second load");
        set_pins(1'b0, 1'b1, "R7 second word at outputs");
        set_pins(1'b1, 1'b1, "R3 close after second word");

        wait (q.size() == 0);
        wait_neg(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule